// File: doc/BRIEF.md
# Write-Protection Register with One-Time Lock

This block holds the write-protection state of a serial word-organised EEPROM. It keeps an 8-bit boundary address, a protect flag and a one-time lock bit. From this state it decides whether a single-word write, a page write or a whole-array write may proceed. Instruction decoding upstream delivers a one-cycle strobe with the 2-bit opcode, the address field and the level of the protection-select pin. The write-enable latch level comes in next to it. The block carries out the protection instructions that arrive while the select pin is high: readback, boundary write, clear, arm and permanent lock.

The protect flag uses an inverted sense. When it reads 1 the register is cleared and no address is protected. When it reads 0, every word at or above the boundary is protected. The non-volatile cells are modelled as registers. A synchronous reset puts them in the cleared, unlocked and unarmed state.

Top module: `prot_guard`

## Requirements
- R1: After reset the boundary is all ones, the flag is 1, the lock bit is 0 and the block is not armed. A readback then returns 9'h1FF.
- R2: A strobe with the select pin high and opcode 2'b10 is a readback. One cycle later `rd_valid` is high for one cycle and `rd_value` holds {boundary[7:0], flag} with the flag in bit 0. `rd_valid` is low in every other cycle.
- R3: A strobe with the select pin high, opcode 2'b00 and address bits [7:6] = 2'b11 arms the block, but only when the write-enable latch is high. Without the latch it has no effect.
- R4: A strobe with the select pin high and opcode 2'b01 is a boundary write. It loads the address as the boundary and sets the flag to 0. It takes effect only when the block is armed, the latch is high and the lock bit is 0. In every other case it is ignored.
- R5: A strobe with the select pin high, opcode 2'b11 and an all-ones address clears the register: boundary all ones, flag 1. It has the same conditions as R4. Opcode 2'b11 with any other address does nothing.
- R6: A strobe with the select pin high, opcode 2'b00 and address 8'h00 sets the lock bit, under the same conditions as R4. Once the lock bit is set, boundary writes, clears and locks are ignored for good.
- R7: A decoded boundary write, clear or lock disarms the block, whether or not it took effect. A readback leaves the armed state unchanged.
- R8: Strobes with the select pin low change no protection state and produce no readback.
- R9: With `chk_count` = 1 and `chk_all` = 0, `chk_allow` is 1 exactly when the flag is 1 or `chk_addr` is below the boundary.
- R10: With `chk_count` = N (1 to 4) and `chk_all` = 0, the page write covers N words. Each word address keeps `chk_addr[7:2]` and uses low bits (`chk_addr[1:0]` + i) mod 4, for i = 0..N-1. `chk_allow` is 1 only if the flag is 1 or every one of these addresses is below the boundary. With `chk_count` = 0, `chk_allow` is 1.
- R11: With `chk_all` = 1, `chk_allow` equals the flag, whatever the address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | One-cycle strobe for a decoded instruction |
| pre_pin | input | 1 | Protection-select pin level during the instruction |
| instr_op | input | 2 | Instruction opcode |
| instr_addr | input | 8 | Instruction address field |
| wel | input | 1 | Write-enable latch level |
| chk_addr | input | 8 | First word address of the write under test |
| chk_count | input | 3 | Number of words in the write under test |
| chk_all | input | 1 | Write under test is a whole-array write |
| chk_allow | output | 1 | Write is permitted |
| rd_valid | output | 1 | Readback value is valid |
| rd_value | output | 9 | Boundary and flag readback |

## Verification
The hardest state to reach is the locked one, and what matters there is that later modifying instructions cannot get through. A boundary write only succeeds after an arm issued with the latch high, with no modifying attempt in between. Because of that, random stimulus seldom produces well-ordered arm/modify pairs. The bench therefore issues random instructions with a bias toward arm strobes. A reference model follows the armed state and checks every readback and verdict against it. Near the end, a directed sequence sets the lock and then tries every way of changing the register.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        OP_ARM_LOCK = 2'b00,
        OP_SET_BND  = 2'b01,
        OP_READBACK = 2'b10,
        OP_CLEAR    = 2'b11
    } prot_op_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic clr;
        logic arm;
        logic lock;
    } prot_cmd_t;

    localparam prot_cmd_t CMD_NONE = '{rd: 1'b0, wr: 1'b0, clr: 1'b0, arm: 1'b0, lock: 1'b0};

    function automatic logic is_modify(input prot_cmd_t c);
        return c.wr | c.clr | c.lock;
    endfunction

endpackage

// File: rtl/prot_decode.sv
module prot_decode
    import prot_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          pre,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    output prot_cmd_t     cmd
);

    prot_op_e op_e;

    always_comb begin
        op_e = prot_op_e'(op);
        cmd  = CMD_NONE;
        if (valid && pre) begin
            unique case (op_e)
                OP_READBACK: cmd.rd  = 1'b1;
                OP_SET_BND:  cmd.wr  = 1'b1;
                OP_CLEAR:    cmd.clr = &addr;
                OP_ARM_LOCK: begin
                    cmd.arm  = (addr[AW-1:AW-2] == 2'b11);
                    cmd.lock = (addr == '0);
                end
                default: cmd = CMD_NONE;
            endcase
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.rd, cmd.wr, cmd.clr, cmd.arm, cmd.lock})); // R8

    AST_NO_CMD_WITHOUT_PRE: assert property (@(posedge clk) disable iff (rst)
        !pre |-> (cmd == CMD_NONE)); // R8

endmodule

// File: rtl/prot_store.sv
module prot_store
    import prot_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  prot_cmd_t     cmd,
    input  logic [AW-1:0] addr,
    input  logic          wel,
    output logic [AW-1:0] bound_q,
    output logic          flag_q,
    output logic          otp_q,
    output logic          rd_valid,
    output logic [AW:0]   rd_value
);

    logic armed_q;
    logic grant;

    assign grant = armed_q & wel & ~otp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q  <= '1;
            flag_q   <= 1'b1;
            otp_q    <= 1'b0;
            armed_q  <= 1'b0;
            rd_valid <= 1'b0;
            rd_value <= '0;
        end else begin
            rd_valid <= cmd.rd;
            if (cmd.rd) begin
                rd_value <= {bound_q, flag_q};
            end
            if (cmd.arm && wel) begin
                armed_q <= 1'b1;
            end else if (is_modify(cmd)) begin
                armed_q <= 1'b0;
            end
            if (grant) begin
                if (cmd.wr) begin
                    bound_q <= addr;
                    flag_q  <= 1'b0;
                end else if (cmd.clr) begin
                    bound_q <= '1;
                    flag_q  <= 1'b1;
                end else if (cmd.lock) begin
                    otp_q   <= 1'b1;
                end
            end
        end
    end

    AST_OTP_STICKY: assert property (@(posedge clk) disable iff (rst)
        otp_q |=> otp_q); // R6

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        otp_q |=> ($stable(bound_q) && $stable(flag_q))); // R6

    AST_NEED_ARM: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> ($stable(bound_q) && $stable(flag_q) && $stable(otp_q))); // R4

    AST_RD_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd.rd)); // R2

    AST_DISARM: assert property (@(posedge clk) disable iff (rst)
        (is_modify(cmd) && !cmd.arm) |=> !armed_q); // R7

endmodule

// File: rtl/prot_verdict.sv
module prot_verdict #(
    parameter int AW         = 8,
    parameter int PAGE_WORDS = 4,
    parameter int PB         = $clog2(PAGE_WORDS),
    parameter int CW         = $clog2(PAGE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bound,
    input  logic          flag,
    input  logic [AW-1:0] chk_addr,
    input  logic [CW-1:0] chk_count,
    input  logic          chk_all,
    output logic          allow
);

    logic [PAGE_WORDS-1:0] lane_hit;

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_lane
        logic [PB-1:0] low;
        logic [AW-1:0] lane_addr;
        assign low       = chk_addr[PB-1:0] + PB'(i);
        assign lane_addr = {chk_addr[AW-1:PB], low};
        assign lane_hit[i] = (CW'(i) < chk_count) && (lane_addr >= bound);
    end

    always_comb begin
        if (chk_all) begin
            allow = flag;
        end else begin
            allow = flag | ~(|lane_hit);
        end
    end

    AST_ZERO_BOUND_DENY: assert property (@(posedge clk) disable iff (rst)
        (!flag && bound == '0 && chk_count != '0) |-> !allow); // R9

    AST_ALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (chk_all && !flag) |-> !allow); // R11

    AST_CLEARED_OPEN: assert property (@(posedge clk) disable iff (rst)
        flag |-> allow); // R10

endmodule

// File: rtl/prot_guard.sv
module prot_guard
    import prot_pkg::*;
#(
    parameter int AW         = 8,
    parameter int PAGE_WORDS = 4,
    localparam int CW        = $clog2(PAGE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    input  logic          pre_pin,
    input  logic [1:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    input  logic          wel,
    input  logic [AW-1:0] chk_addr,
    input  logic [CW-1:0] chk_count,
    input  logic          chk_all,
    output logic          chk_allow,
    output logic          rd_valid,
    output logic [AW:0]   rd_value
);

    prot_cmd_t     cmd;
    logic [AW-1:0] bound_q;
    logic          flag_q;
    logic          otp_q;

    prot_decode #(.AW(AW)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .valid (instr_valid),
        .pre   (pre_pin),
        .op    (instr_op),
        .addr  (instr_addr),
        .cmd   (cmd)
    );

    prot_store #(.AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr     (instr_addr),
        .wel      (wel),
        .bound_q  (bound_q),
        .flag_q   (flag_q),
        .otp_q    (otp_q),
        .rd_valid (rd_valid),
        .rd_value (rd_value)
    );

    prot_verdict #(.AW(AW), .PAGE_WORDS(PAGE_WORDS)) u_verdict (
        .clk       (clk),
        .rst       (rst),
        .bound     (bound_q),
        .flag      (flag_q),
        .chk_addr  (chk_addr),
        .chk_count (chk_count),
        .chk_all   (chk_all),
        .allow     (chk_allow)
    );

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid || $past(instr_valid)); // R2

endmodule

// File: tb/tb_prot_guard.sv
module tb_prot_guard;

    logic       clk = 1'b0;
    logic       rst;
    logic       instr_valid, pre_pin, wel, chk_all;
    logic [1:0] instr_op;
    logic [7:0] instr_addr, chk_addr;
    logic [2:0] chk_count;
    logic       chk_allow, rd_valid;
    logic [8:0] rd_value;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_bound;
    logic       m_flag, m_otp, m_armed;

    prot_guard dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .pre_pin(pre_pin),
        .instr_op(instr_op), .instr_addr(instr_addr), .wel(wel),
        .chk_addr(chk_addr), .chk_count(chk_count), .chk_all(chk_all),
        .chk_allow(chk_allow), .rd_valid(rd_valid), .rd_value(rd_value)
    );

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_allow(input logic [7:0] a, input int n, input logic all);
        if (all) return m_flag;
        if (m_flag) return 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] la;
            la = {a[7:2], 2'(a[1:0] + 2'(i))};
            if (la >= m_bound) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic model(input logic pre, input logic [1:0] op, input logic [7:0] a, input logic w);
        logic g, mod;
        if (!pre) return;
        g   = m_armed && w && !m_otp;
        mod = (op == 2'b01) || (op == 2'b11 && a == 8'hFF) || (op == 2'b00 && a == 8'h00);
        if (op == 2'b00 && a[7:6] == 2'b11) begin
            if (w) m_armed = 1'b1;
        end else if (mod) begin
            if (g) begin
                if (op == 2'b01) begin m_bound = a; m_flag = 1'b0; end
                else if (op == 2'b11) begin m_bound = 8'hFF; m_flag = 1'b1; end
                else m_otp = 1'b1;
            end
            m_armed = 1'b0;
        end
    endtask

    // drives one strobe; returns after the next negedge with rd_valid sampled
    task automatic issue(input logic pre, input logic [1:0] op, input logic [7:0] a,
                         input logic w, input string req);
        logic exp_rd;
        logic [8:0] exp_val;
        exp_rd  = pre && op == 2'b10;
        exp_val = {m_bound, m_flag};
        @(negedge clk);
        instr_valid = 1'b1; pre_pin = pre; instr_op = op; instr_addr = a; wel = w;
        @(negedge clk);
        instr_valid = 1'b0;
        model(pre, op, a, w);
        check(rd_valid == exp_rd, {req, " rd_valid"}, rd_valid, exp_rd);
        if (exp_rd)
            check(rd_value == exp_val, {req, " readback"}, rd_value, exp_val);
    endtask

    task automatic readback(input string req);
        issue(1'b1, 2'b10, 8'h00, 1'b0, req);
    endtask

    task automatic verdict(input logic [7:0] a, input int n, input logic all, input string req);
        logic e;
        chk_addr = a; chk_count = 3'(n); chk_all = all;
        #1;
        e = exp_allow(a, n, all);
        check(chk_allow == e, req, chk_allow, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; instr_valid = 0; pre_pin = 0; instr_op = 0; instr_addr = 0;
        wel = 0; chk_addr = 0; chk_count = 1; chk_all = 0;
        m_bound = 8'hFF; m_flag = 1; m_otp = 0; m_armed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        readback("R1");
        verdict(8'hFF, 1, 0, "R1 cleared allows top");
        verdict(8'h00, 0, 1, "R11 write-all after reset");

        // R3: arm without latch has no effect
        issue(1, 2'b00, 8'hC0, 0, "R3 arm no wel");
        issue(1, 2'b01, 8'h40, 1, "R3 write unarmed");
        readback("R3 unchanged");

        // R4/R2: arm then write
        issue(1, 2'b00, 8'hD5, 1, "R3 arm");
        readback("R7 read keeps arm");
        issue(1, 2'b01, 8'h40, 1, "R4 set boundary");
        readback("R2 R4 readback");
        verdict(8'h3F, 1, 0, "R9 just below");
        verdict(8'h40, 1, 0, "R9 at boundary");
        verdict(8'h3E, 2, 0, "R10 page below");
        verdict(8'h3E, 3, 0, "R10 page wraps in row");
        verdict(8'h3F, 2, 0, "R10 page wrap low");
        verdict(8'h80, 0, 0, "R10 zero count");
        verdict(8'h00, 1, 1, "R11 write-all protected");

        // R7: failed attempt disarms
        issue(1, 2'b00, 8'hC0, 1, "R3 arm again");
        issue(1, 2'b01, 8'h10, 0, "R7 write w/o wel");
        issue(1, 2'b01, 8'h10, 1, "R7 write after disarm");
        readback("R7 boundary kept");

        // R5: clear address must be all ones
        issue(1, 2'b00, 8'hC0, 1, "R3 arm");
        issue(1, 2'b11, 8'hFE, 1, "R5 bad clear");
        readback("R5 bad clear ignored");
        issue(1, 2'b00, 8'hC0, 1, "R3 arm");
        issue(1, 2'b11, 8'hFF, 1, "R5 clear");
        readback("R5 cleared");

        // R8: select pin low
        issue(1, 2'b00, 8'hC0, 1, "R3 arm");
        issue(0, 2'b01, 8'h22, 1, "R8 pre low write");
        issue(0, 2'b10, 8'h00, 1, "R8 pre low read");
        issue(1, 2'b01, 8'h22, 1, "R8 arm survives");
        readback("R8 result");

        // random phase
        for (int it = 0; it < 600; it++) begin
            logic [1:0] op;
            logic [7:0] a;
            int k;
            k = $urandom_range(0, 9);
            a = 8'($urandom);
            case (k)
                0, 1, 2: begin op = 2'b00; a[7:6] = 2'b11; end
                3, 4, 5: op = 2'b01;
                6:       begin op = 2'b11; if ($urandom_range(0, 1) == 1) a = 8'hFF; end
                7:       op = 2'b10;
                default: begin op = 2'b00; a[7:6] = 2'($urandom_range(0, 2)); end
            endcase
            if (op == 2'b00 && a == 8'h00) a = 8'h01;
            issue($urandom_range(0, 9) != 0, op, a, $urandom_range(0, 4) != 0, "R4 R5 R7 random");
            for (int j = 0; j < 3; j++)
                verdict(8'($urandom), $urandom_range(0, 4), $urandom_range(0, 7) == 0,
                        "R9 R10 R11 random");
            if (it % 8 == 0) readback("R2 random");
        end

        // R6: lock
        issue(1, 2'b00, 8'hC0, 1, "R3 arm");
        issue(1, 2'b01, 8'h30, 1, "R4 boundary before lock");
        issue(1, 2'b00, 8'hC0, 1, "R3 arm");
        issue(1, 2'b00, 8'h00, 1, "R6 lock");
        issue(1, 2'b00, 8'hC0, 1, "R3 arm locked");
        issue(1, 2'b01, 8'h90, 1, "R6 write locked");
        issue(1, 2'b00, 8'hC0, 1, "R3 arm locked");
        issue(1, 2'b11, 8'hFF, 1, "R6 clear locked");
        readback("R6 frozen");
        verdict(8'h2F, 1, 0, "R6 verdict below");
        verdict(8'h30, 1, 0, "R6 verdict at");
        verdict(8'h2D, 4, 0, "R10 page full row");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule